// File: doc/BRIEF.md
# Synchronous RAM with Selectable Collision Policy

This block is a single-clock memory with one write port and one read port. A write stores a word at the write address on the rising edge. Every rising edge also registers a read of the read address. A build-time parameter sets what the read returns when it hits the word being written on the same edge. It can return the contents from before the write, forward the incoming write data, or keep the read output at its previous value.

A second parameter inserts an extra output register, which raises the read latency from one cycle to two and eases timing on the read path. Each read request carries a valid flag and a tag. Both pass through a delay line whose length always equals the read latency, so a consumer can pair every returned word with the request that produced it and needs no counting of its own.

The storage array has no reset and must be written before it is read. The pipeline registers on the read side reset to zero.

Top module: `coll_ram`

## Requirements
- R1: With the output register disabled (OUT_REG = 0), a non-colliding read presented before rising edge N shows the stored word on rd_data_o after edge N, in every collision policy.
- R2: With the output register enabled (OUT_REG = 1), the same non-colliding read shows its word one edge later, after edge N+1, in every collision policy.
- R3: With POLICY = COLL_OLD (encoding 0), a colliding read returns the word stored at that address before the write on the same edge.
- R4: With POLICY = COLL_NEW (encoding 1), a colliding read returns wr_data_i from the same edge.
- R5: With POLICY = COLL_HOLD (encoding 2), a colliding read leaves the first-stage read value unchanged from the previous edge.
- R6: A collision exists only when wr_en_i is high and rd_addr_i equals wr_addr_i on the same edge. With wr_en_i low, equal addresses give an ordinary read of the stored word.
- R7: rd_valid_o and rd_tag_o repeat rd_valid_i and rd_tag_i delayed by exactly the read latency (1 + OUT_REG edges).
- R8: While rst_ni is low, rd_valid_o, rd_tag_o and rd_data_o are all zero.
- R9: With OUT_REG = 1, the word chosen by the collision policy in the first stage reaches rd_data_o one edge later without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the read pipeline |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_valid_i | input | 1 | Read request valid flag, carried beside the data |
| rd_addr_i | input | ADDR_W | Read address, sampled every edge |
| rd_tag_i | input | TAG_W | Request tag carried beside the data |
| rd_valid_o | output | 1 | Valid flag aligned with rd_data_o |
| rd_tag_o | output | TAG_W | Tag aligned with rd_data_o |
| rd_data_o | output | DATA_W | Read data |

## Verification
All six combinations of policy and latency run side by side on the same stimulus and are compared with a behavioural model every cycle. A fill pass writes while reading a different address, and a read-only sweep follows. Together these confirm the basic latency of each configuration. A read at the write address with the write enable low confirms that matching addresses alone do not count as a collision.

Directed collisions, including several on the same address back to back, separate the three policies. On those cycles the old contents, the new data and the held value all differ from one another. A final random phase keeps addresses in a narrow range so collisions, idle cycles and tag changes mix freely, which catches any misalignment between the tag and data pipelines.

// File: rtl/coll_ram_pkg.sv
package coll_ram_pkg;
  typedef enum logic [1:0] {
    COLL_OLD  = 2'd0,
    COLL_NEW  = 2'd1,
    COLL_HOLD = 2'd2
  } coll_policy_e;
endpackage

// File: rtl/coll_ram_delay.sv
module coll_ram_delay #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/coll_ram_core.sv
module coll_ram_core
  import coll_ram_pkg::*;
#(
  parameter int           DATA_W = 32,
  parameter int           DEPTH  = 256,
  parameter coll_policy_e POLICY = COLL_OLD,
  localparam int          ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q, rd_d, arr_rd;
  logic              coll;

  assign coll   = wr_en_i && (rd_addr_i == wr_addr_i);
  assign arr_rd = mem_q[rd_addr_i];

  // array: no reset by intent
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  generate
    if (POLICY == COLL_NEW) begin : g_new
      assign rd_d = coll ? wr_data_i : arr_rd;
      // R4
      new_on_coll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coll |=> rd_q == $past(wr_data_i));
    end else if (POLICY == COLL_HOLD) begin : g_hold
      assign rd_d = coll ? rd_q : arr_rd;
      // R5
      hold_on_coll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coll |=> $stable(rd_q));
    end else begin : g_old
      // read samples pre-write contents
      assign rd_d = arr_rd;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/coll_ram.sv
module coll_ram
  import coll_ram_pkg::*;
#(
  parameter int           DATA_W  = 32,
  parameter int           DEPTH   = 256,
  parameter int           TAG_W   = 4,
  parameter coll_policy_e POLICY  = COLL_OLD,
  parameter bit           OUT_REG = 1'b0,
  localparam int          ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LAT = 1 + int'(OUT_REG);

  logic [DATA_W-1:0] s1_data;
  logic [TAG_W:0]    side_q;

  coll_ram_core #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .POLICY (POLICY)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (s1_data)
  );

  generate
    if (OUT_REG) begin : g_oreg
      // stage 2 passes stage-1 result through untouched
      coll_ram_delay #(.W(DATA_W), .STAGES(1)) u_oreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (s1_data),
        .q_o    (rd_data_o)
      );
    end else begin : g_noreg
      assign rd_data_o = s1_data;
    end
  endgenerate

  coll_ram_delay #(.W(TAG_W + 1), .STAGES(LAT)) u_side (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rd_valid_i, rd_tag_i}),
    .q_o    (side_q)
  );

  assign rd_valid_o = side_q[TAG_W];
  assign rd_tag_o   = side_q[TAG_W-1:0];

  generate
    if (OUT_REG) begin : g_chk2
      // R7
      valid_lat2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o == $past(rd_valid_i, 2));
      // R7
      tag_lat2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> rd_tag_o == $past(rd_tag_i, 2));
    end else begin : g_chk1
      // R7
      valid_lat1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o == $past(rd_valid_i));
      // R7
      tag_lat1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> rd_tag_o == $past(rd_tag_i));
    end
  endgenerate
endmodule

// File: tb/tb_coll_ram.sv
`timescale 1ns/1ps
module tb_coll_ram;
  import coll_ram_pkg::*;

  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int TW    = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int NCFG  = 6;  // index = policy*2 + out_reg

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          we = 1'b0, rv = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic [TW-1:0] tg = '0;

  logic [DW-1:0] dout_w [NCFG];
  logic [TW-1:0] tag_w  [NCFG];
  logic          vld_w  [NCFG];

  for (genvar p = 0; p < 3; p++) begin : g_p
    for (genvar l = 0; l < 2; l++) begin : g_l
      coll_ram #(
        .DATA_W(DW), .DEPTH(DEPTH), .TAG_W(TW),
        .POLICY(coll_policy_e'(p)), .OUT_REG(l[0])
      ) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .rd_valid_i(rv), .rd_addr_i(ra), .rd_tag_i(tg),
        .rd_valid_o(vld_w[p*2+l]), .rd_tag_o(tag_w[p*2+l]),
        .rd_data_o(dout_w[p*2+l])
      );
    end
  end

  // behavioural reference
  logic [DW-1:0] mem_m [DEPTH];
  bit            known_m [DEPTH];
  logic [DW-1:0] e1_d [NCFG], e2_d [NCFG];
  bit            e1_k [NCFG], e2_k [NCFG];
  string         e1_r [NCFG], e2_r [NCFG];
  logic [TW:0]   t1 [NCFG], t2 [NCFG];

  int n_chk = 0, n_fail = 0;
  bit run_chk = 1'b1;

  initial for (int i = 0; i < DEPTH; i++) known_m[i] = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCFG; c++) begin
        e1_d[c] = '0; e2_d[c] = '0; e1_k[c] = 1'b1; e2_k[c] = 1'b1;
        e1_r[c] = "R8"; e2_r[c] = "R8"; t1[c] = '0; t2[c] = '0;
      end
    end else begin
      for (int c = 0; c < NCFG; c++) begin
        int    pol;
        bit    l2, hit;
        logic [DW-1:0] nd;
        bit    nk;
        string nr;
        pol = c / 2;
        l2  = (c % 2) == 1;
        hit = we && (ra == wa);
        if (!hit) begin
          nd = mem_m[ra]; nk = known_m[ra];
          nr = (ra == wa) ? "R6" : (l2 ? "R2" : "R1");
        end else if (pol == 0) begin
          nd = mem_m[ra]; nk = known_m[ra]; nr = "R3";
        end else if (pol == 1) begin
          nd = wd; nk = 1'b1; nr = "R4";
        end else begin
          nd = e1_d[c]; nk = e1_k[c]; nr = "R5";
        end
        if (hit && l2) nr = {"R9 ", nr};
        e2_d[c] = e1_d[c]; e2_k[c] = e1_k[c]; e2_r[c] = e1_r[c];
        e1_d[c] = nd; e1_k[c] = nk; e1_r[c] = nr;
        t2[c] = t1[c]; t1[c] = {rv, tg};
      end
      if (we) begin mem_m[wa] = wd; known_m[wa] = 1'b1; end
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      for (int c = 0; c < NCFG; c++) begin
        logic [DW-1:0] ed;
        bit            ek;
        string         er;
        logic [TW:0]   et;
        ed = (c % 2) ? e2_d[c] : e1_d[c];
        ek = (c % 2) ? e2_k[c] : e1_k[c];
        er = (c % 2) ? e2_r[c] : e1_r[c];
        et = (c % 2) ? t2[c] : t1[c];
        if (ek) begin
          n_chk++;
          if (dout_w[c] !== ed) begin
            n_fail++;
            $display("FAIL %s cfg%0d data: got %h exp %h at %0t", er, c, dout_w[c], ed, $time);
          end
        end
        n_chk++;
        if ({vld_w[c], tag_w[c]} !== et) begin
          n_fail++;
          $display("FAIL %s cfg%0d valid/tag: got %b/%h exp %b/%h at %0t",
                   rst_n ? "R7" : "R8", c, vld_w[c], tag_w[c], et[TW], et[TW-1:0], $time);
        end
      end
    end
  end

  task automatic drive(input logic e, input int a_w, input logic [DW-1:0] d,
                       input logic v, input int a_r, input int t);
    @(negedge clk);
    we = e; wa = AW'(a_w); wd = d; rv = v; ra = AW'(a_r); tg = TW'(t);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state checked each negedge while low
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1/R2: fill while reading the previous address
    for (int a = 0; a < DEPTH; a++)
      drive(1'b1, a, DW'(16'h1000 + a * 37), (a % 3) != 0, (a + DEPTH - 1) % DEPTH, a);
    // R1/R2: read-only sweep
    for (int a = 0; a < DEPTH; a++) drive(1'b0, 0, '0, 1'b1, a, a + 1);
    // R6: equal addresses, write disabled
    drive(1'b0, 3, 16'hBAD0, 1'b1, 3, 5);
    drive(1'b0, 7, 16'hBAD1, 1'b1, 7, 6);
    // R3/R4/R5/R9: isolated then back-to-back collisions
    drive(1'b1, 5, 16'hA5A5, 1'b1, 5, 7);
    drive(1'b0, 0, '0, 1'b1, 9, 8);
    drive(1'b1, 5, 16'h1234, 1'b1, 5, 9);
    drive(1'b1, 5, 16'h5678, 1'b1, 5, 10);
    drive(1'b1, 5, 16'h9ABC, 1'b0, 5, 11);
    drive(1'b0, 0, '0, 1'b1, 5, 12);
    // random mix on a narrow range
    for (int i = 0; i < 400; i++)
      drive(1'($urandom_range(0, 1)), $urandom_range(0, 3), DW'($urandom),
            1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 15));
    repeat (4) drive(1'b0, 0, '0, 1'b0, 0, 0);
    @(negedge clk);
    @(posedge clk);
    run_chk = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule